// File: doc/BRIEF.md
# Graphics Palette Lookup and Video Blend Stage

This stage sits at the end of an on-screen graphics path. On each pixel clock it takes one graphics pixel code and the co-timed video pixel (Y, U and V). The code is 2, 4 or 8 bits wide, and the width can change from region to region. A narrow code can pass through a small remap table, which points it at a chosen part of a larger palette. The resulting index reads a palette word that holds a graphics colour and a 6-bit opacity. The graphics colour is then blended over the video in 64 steps.

A box-active flag says whether a graphics box covers the current pixel. Where no box is present the video passes through unchanged. The video is delayed inside the block by the same number of cycles as the lookup, so every output pixel combines a graphics and a video sample that entered together. A host loads both tables through simple write ports, and may do so while pixels are flowing.

Top module: `osd_clut_mixer`

## Requirements
- R1: While reset is held, and on the first sample after reset, out_y, out_u and out_v are all zero.
- R2: Every pixel reaches the outputs exactly three clock edges after it is sampled. The video sample that entered with it is the one that gets mixed.
- R3: When box_active was low for a pixel, the outputs equal that pixel's video unchanged, whatever the graphics code and both tables hold.
- R4: gfx_depth encodes the pixel width: 0 means 2-bit, 1 means 4-bit, and 2 or 3 mean 8-bit. An 8-bit code always indexes the palette directly, and remap_en and remap_narrow have no effect on it.
- R5: When remapping is off, a 2-bit or 4-bit pixel uses only code bits [1:0] or [3:0]. Those bits are zero-extended to form the palette index, and the higher code bits are ignored.
- R6: For a 4-bit pixel with remap_en high, the index is the 8-bit remap entry addressed by code bits [3:0].
- R7: For a 2-bit pixel with remap_en high and remap_narrow low, the index is the full 8-bit remap entry addressed by code bits [1:0], which gives a 4-to-256 mapping.
- R8: For a 2-bit pixel with remap_en and remap_narrow both high, the index is bits [3:0] of the remap entry addressed by code bits [1:0], zero-extended, which gives a 4-to-16 mapping. remap_narrow has no effect for 4-bit pixels.
- R9: A palette word is laid out as Y in [29:22], U in [21:14], V in [13:6] and opacity T in [5:0]. Each output component is (video*(63-T) + graphics*T + 31) / 63, rounded down. So T=0 yields the video and T=63 yields the graphics colour.
- R10: A palette write that lands on the same edge as the palette read for an earlier pixel leaves that read with the old word. The pixel that follows sees the new word.
- R11: A remap-table write on the same edge as a pixel that uses that entry leaves that pixel with the old entry. The pixel sampled on the next edge uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gfx_code | input | 8 | Graphics pixel code |
| gfx_depth | input | 2 | Pixel width select (0: 2-bit, 1: 4-bit, 2/3: 8-bit) |
| remap_en | input | 1 | Route narrow codes through the remap table |
| remap_narrow | input | 1 | For 2-bit codes, keep only 4 bits of the remap entry |
| box_active | input | 1 | A graphics box covers this pixel |
| vid_y | input | 8 | Video luma |
| vid_u | input | 8 | Video blue-difference chroma |
| vid_v | input | 8 | Video red-difference chroma |
| map_we | input | 1 | Remap table write strobe |
| map_waddr | input | 4 | Remap table write address |
| map_wdata | input | 8 | Remap table write data (palette index) |
| clut_we | input | 1 | Palette write strobe |
| clut_waddr | input | 8 | Palette write address |
| clut_wdata | input | 30 | Palette word {Y,U,V,T} |
| out_y | output | 8 | Blended luma |
| out_u | output | 8 | Blended blue-difference chroma |
| out_v | output | 8 | Blended red-difference chroma |

## Verification
Some properties are checked on every cycle from the internal stage signals. Where no box is present, the video must pass through. At opacity 0 the result must be pure video and at opacity 63 pure graphics, and any blend must fall between the two sources. Narrow codes must never produce an index above their reach. Other behaviour can only be shown by the bench's scenarios. These include the exact rounding of the blend, the content each remap mode selects, and the three-cycle alignment of video with graphics. They also include the ordering of a table write against a lookup in flight. The bench sets up each of these on purpose and compares the result with its own model of the lookup.

// File: rtl/gcm_pkg.sv
package gcm_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned COMP_W = 8;
  localparam int unsigned TR_W   = 6;
  localparam int unsigned MAP_N  = 16;

  typedef enum logic [1:0] {
    DEPTH_2  = 2'd0,
    DEPTH_4  = 2'd1,
    DEPTH_8  = 2'd2,
    DEPTH_8B = 2'd3
  } depth_e;
endpackage

// File: rtl/gcm_index_map.sv
module gcm_index_map #(
  parameter int unsigned PIX_W = gcm_pkg::PIX_W,
  parameter int unsigned MAP_N = gcm_pkg::MAP_N,
  localparam int unsigned MAP_AW = $clog2(MAP_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  code,
  input  logic [1:0]        depth,
  input  logic              remap_en,
  input  logic              narrow,
  input  logic              wr_en,
  input  logic [MAP_AW-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  output logic [PIX_W-1:0]  idx_q
);
  import gcm_pkg::*;

  logic [PIX_W-1:0] map_q [MAP_N];
  logic [PIX_W-1:0] ent2, ent4, idx_d;

  assign ent2 = map_q[MAP_AW'(code[1:0])];
  assign ent4 = map_q[MAP_AW'(code[3:0])];

  always_comb begin
    idx_d = '0;
    case (depth_e'(depth))
      DEPTH_2: begin
        if (!remap_en)   idx_d[1:0] = code[1:0];
        else if (narrow) idx_d[3:0] = ent2[3:0];
        else             idx_d = ent2;
      end
      DEPTH_4: begin
        if (!remap_en) idx_d[3:0] = code[3:0];
        else           idx_d = ent4;
      end
      default: idx_d = code;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(MAP_N); i++) map_q[i] <= '0;
    end else if (wr_en) begin
      map_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/gcm_colour_store.sv
module gcm_colour_store #(
  parameter int unsigned ADDR_W  = gcm_pkg::PIX_W,
  parameter int unsigned WORD_W  = 3 * gcm_pkg::COMP_W + gcm_pkg::TR_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_q
);
  logic [WORD_W-1:0] mem [DEPTH];

  // read takes the word held before this edge's write
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/gcm_blend.sv
module gcm_blend #(
  parameter int unsigned COMP_W = gcm_pkg::COMP_W,
  parameter int unsigned TR_W   = gcm_pkg::TR_W,
  parameter int unsigned NCOMP  = 3,
  localparam int unsigned MAXT  = (1 << TR_W) - 1,
  localparam int unsigned SUM_W = COMP_W + TR_W + 1,
  localparam int unsigned VEC_W = NCOMP * COMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             box,
  input  logic [VEC_W-1:0] gfx,
  input  logic [TR_W-1:0]  t,
  input  logic [VEC_W-1:0] vid,
  output logic [VEC_W-1:0] out_q
);
  function automatic logic [COMP_W-1:0] mix(input logic [COMP_W-1:0] g,
                                            input logic [COMP_W-1:0] v,
                                            input logic [TR_W-1:0]   a);
    logic [SUM_W-1:0] s;
    s = SUM_W'(v) * SUM_W'(TR_W'(MAXT) - a) + SUM_W'(g) * SUM_W'(a)
        + SUM_W'(MAXT / 2);
    return COMP_W'(s / SUM_W'(MAXT));
  endfunction

  logic [VEC_W-1:0] mixed;

  for (genvar c = 0; c < int'(NCOMP); c++) begin : g_comp
    assign mixed[c*COMP_W +: COMP_W] =
      mix(gfx[c*COMP_W +: COMP_W], vid[c*COMP_W +: COMP_W], t);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= box ? mixed : vid;
  end
endmodule

// File: rtl/osd_clut_mixer.sv
module osd_clut_mixer #(
  parameter int unsigned PIX_W  = gcm_pkg::PIX_W,
  parameter int unsigned COMP_W = gcm_pkg::COMP_W,
  parameter int unsigned TR_W   = gcm_pkg::TR_W,
  parameter int unsigned MAP_N  = gcm_pkg::MAP_N
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PIX_W-1:0]             gfx_code,
  input  logic [1:0]                   gfx_depth,
  input  logic                         remap_en,
  input  logic                         remap_narrow,
  input  logic                         box_active,
  input  logic [COMP_W-1:0]            vid_y,
  input  logic [COMP_W-1:0]            vid_u,
  input  logic [COMP_W-1:0]            vid_v,
  input  logic                         map_we,
  input  logic [$clog2(MAP_N)-1:0]     map_waddr,
  input  logic [PIX_W-1:0]             map_wdata,
  input  logic                         clut_we,
  input  logic [PIX_W-1:0]             clut_waddr,
  input  logic [3*COMP_W+TR_W-1:0]     clut_wdata,
  output logic [COMP_W-1:0]            out_y,
  output logic [COMP_W-1:0]            out_u,
  output logic [COMP_W-1:0]            out_v
);
  localparam int unsigned VEC_W  = 3 * COMP_W;
  localparam int unsigned WORD_W = VEC_W + TR_W;

  // stage signals, named for the bound checker
  logic [PIX_W-1:0]  s1_idx;
  logic              s1_box, s2_box;
  logic [VEC_W-1:0]  s1_vid, s2_vid;
  logic [WORD_W-1:0] s2_word;
  logic [VEC_W-1:0]  s2_gfx;
  logic [TR_W-1:0]   s2_t;
  logic [VEC_W-1:0]  s3_out;

  gcm_index_map #(.PIX_W(PIX_W), .MAP_N(MAP_N)) u_map (
    .clk(clk), .rst_n(rst_n), .code(gfx_code), .depth(gfx_depth),
    .remap_en(remap_en), .narrow(remap_narrow), .wr_en(map_we),
    .wr_addr(map_waddr), .wr_data(map_wdata), .idx_q(s1_idx)
  );

  gcm_colour_store #(.ADDR_W(PIX_W), .WORD_W(WORD_W)) u_clut (
    .clk(clk), .rst_n(rst_n), .wr_en(clut_we), .wr_addr(clut_waddr),
    .wr_data(clut_wdata), .rd_addr(s1_idx), .rd_q(s2_word)
  );

  assign s2_gfx = s2_word[WORD_W-1:TR_W];
  assign s2_t   = s2_word[TR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_box <= 1'b0;
      s2_box <= 1'b0;
      s1_vid <= '0;
      s2_vid <= '0;
    end else begin
      s1_box <= box_active;
      s2_box <= s1_box;
      s1_vid <= {vid_y, vid_u, vid_v};
      s2_vid <= s1_vid;
    end
  end

  gcm_blend #(.COMP_W(COMP_W), .TR_W(TR_W), .NCOMP(3)) u_blend (
    .clk(clk), .rst_n(rst_n), .box(s2_box), .gfx(s2_gfx), .t(s2_t),
    .vid(s2_vid), .out_q(s3_out)
  );

  assign {out_y, out_u, out_v} = s3_out;
endmodule

// File: rtl/gcm_checker.sv
module gcm_checker #(
  parameter int unsigned PIX_W  = gcm_pkg::PIX_W,
  parameter int unsigned COMP_W = gcm_pkg::COMP_W,
  parameter int unsigned TR_W   = gcm_pkg::TR_W,
  localparam int unsigned VEC_W = 3 * COMP_W,
  localparam int unsigned MAXT  = (1 << TR_W) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        gfx_depth,
  input logic              remap_en,
  input logic              remap_narrow,
  input logic [PIX_W-1:0]  s1_idx,
  input logic              s2_box,
  input logic [VEC_W-1:0]  s2_gfx,
  input logic [VEC_W-1:0]  s2_vid,
  input logic [TR_W-1:0]   s2_t,
  input logic [COMP_W-1:0] out_y,
  input logic [COMP_W-1:0] out_u,
  input logic [COMP_W-1:0] out_v
);
  logic [COMP_W-1:0] gy, vy;
  assign gy = s2_gfx[VEC_W-1 -: COMP_W];
  assign vy = s2_vid[VEC_W-1 -: COMP_W];

  AST_VIDEO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_box |=> {out_y, out_u, out_v} == $past(s2_vid)); // R3

  AST_OPAQUE_GFX: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_box && s2_t == TR_W'(MAXT)) |=> {out_y, out_u, out_v} == $past(s2_gfx)); // R9

  AST_CLEAR_GFX: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_box && s2_t == '0) |=> {out_y, out_u, out_v} == $past(s2_vid)); // R9

  AST_MIX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    s2_box |=> ((out_y >= $past(gy)) || (out_y >= $past(vy))) &&
               ((out_y <= $past(gy)) || (out_y <= $past(vy)))); // R9

  AST_TWO_BIT_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_depth == 2'd0 && !remap_en) |=> s1_idx < PIX_W'(4)); // R5

  AST_FOUR_BIT_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_depth == 2'd1 && !remap_en) |=> s1_idx < PIX_W'(16)); // R5

  AST_NARROW_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_depth == 2'd0 && remap_en && remap_narrow) |=> s1_idx < PIX_W'(16)); // R8
endmodule

bind osd_clut_mixer gcm_checker #(.PIX_W(PIX_W), .COMP_W(COMP_W), .TR_W(TR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gfx_depth(gfx_depth), .remap_en(remap_en),
  .remap_narrow(remap_narrow), .s1_idx(s1_idx), .s2_box(s2_box),
  .s2_gfx(s2_gfx), .s2_vid(s2_vid), .s2_t(s2_t),
  .out_y(out_y), .out_u(out_u), .out_v(out_v)
);

// File: tb/osd_clut_mixer_test.sv
module osd_clut_mixer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  gfx_code = '0;
  logic [1:0]  gfx_depth = '0;
  logic        remap_en = 1'b0, remap_narrow = 1'b0, box_active = 1'b0;
  logic [7:0]  vid_y = '0, vid_u = '0, vid_v = '0;
  logic        map_we = 1'b0;
  logic [3:0]  map_waddr = '0;
  logic [7:0]  map_wdata = '0;
  logic        clut_we = 1'b0;
  logic [7:0]  clut_waddr = '0;
  logic [29:0] clut_wdata = '0;
  logic [7:0]  out_y, out_u, out_v;

  osd_clut_mixer uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit finished = 1'b0;

  // behavioural model
  typedef struct packed { logic box; logic [23:0] vid; logic [7:0] idx; } pa_t;
  typedef struct packed { logic box; logic [23:0] vid; logic [29:0] word; } pb_t;
  pa_t qa[$];
  pb_t qb[$];
  logic [7:0]  m_map [16];
  logic [29:0] m_clut [256];
  logic [23:0] exp_out = '0;

  function automatic int blend_ref(int g, int v, int t);
    int acc;
    acc = v * 63 + (g - v) * t + 31;
    return acc / 63;
  endfunction

  function automatic logic [7:0] idx_ref(logic [7:0] c, logic [1:0] d, logic re, logic nw);
    int k;
    if (d == 2'd0) begin
      k = c % 4;
      if (re) k = nw ? (m_map[k] % 16) : m_map[k];
    end else if (d == 2'd1) begin
      k = c % 16;
      if (re) k = m_map[k];
    end else k = c;
    return 8'(k);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) m_map[i] = '0;
    for (int i = 0; i < 256; i++) m_clut[i] = '0;
  end

  always @(posedge clk) begin
    pa_t a, na;
    pb_t b, nb;
    if (!rst_n) begin
      qa.delete(); qb.delete();
      qa.push_back('0); qb.push_back('0);
      exp_out = '0;
      for (int i = 0; i < 16; i++) m_map[i] = '0;
    end else begin
      b = qb.pop_front();
      if (b.box) begin
        for (int c = 0; c < 3; c++)
          exp_out[c*8 +: 8] = 8'(blend_ref(int'(b.word[6 + c*8 +: 8]),
                                           int'(b.vid[c*8 +: 8]), int'(b.word[5:0])));
      end else exp_out = b.vid;
      a = qa.pop_front();
      nb.box = a.box; nb.vid = a.vid; nb.word = m_clut[a.idx];
      qb.push_back(nb);
      na.box = box_active; na.vid = {vid_y, vid_u, vid_v};
      na.idx = idx_ref(gfx_code, gfx_depth, remap_en, remap_narrow);
      qa.push_back(na);
      if (map_we) m_map[map_waddr] = map_wdata;
      if (clut_we) m_clut[clut_waddr] = clut_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if ({out_y, out_u, out_v} !== exp_out) begin
        errors++;
        $display("FAIL %s: out=%h expected=%h", tag, {out_y, out_u, out_v}, exp_out);
      end
    end
  end

  task automatic pix(input logic [7:0] c, input logic [1:0] d, input logic re,
                     input logic nw, input logic bx);
    gfx_code = c; gfx_depth = d; remap_en = re; remap_narrow = nw; box_active = bx;
    vid_y = 8'($urandom); vid_u = 8'($urandom); vid_v = 8'($urandom);
    @(negedge clk);
    map_we = 1'b0; clut_we = 1'b0;
  endtask

  function automatic logic [29:0] pal(int i);
    return {8'(i), 8'(255 - i), 8'((i * 7) % 256), 6'((i * 5) % 64)};
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({out_y, out_u, out_v} !== 24'h0) begin // R1
      errors++;
      $display("FAIL R1: out=%h expected=000000", {out_y, out_u, out_v});
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({out_y, out_u, out_v} !== 24'h0) begin // R1
      errors++;
      $display("FAIL R1: out=%h expected=000000", {out_y, out_u, out_v});
    end
    // load palette; video passes meanwhile
    tag = "R3";
    for (int i = 0; i < 256; i++) begin
      clut_we = 1'b1; clut_waddr = 8'(i); clut_wdata = pal(i);
      pix(8'($urandom), 2'd2, 1'b0, 1'b0, 1'b0);
    end
    for (int i = 0; i < 16; i++) begin
      map_we = 1'b1; map_waddr = 4'(i); map_wdata = 8'(200 + i * 3);
      pix(8'(i), 2'd1, 1'b1, 1'b0, 1'b0);
    end
    tag = "R4";
    for (int i = 0; i < 256; i++) pix(8'(i), 2'(2 + (i % 2)), 1'(i % 3 == 0), 1'(i % 5 == 0), 1'b1);
    tag = "R5";
    for (int i = 0; i < 64; i++) pix(8'($urandom), 2'(i % 2), 1'b0, 1'(i % 3 == 0), 1'b1);
    tag = "R6";
    for (int i = 0; i < 48; i++) pix(8'($urandom), 2'd1, 1'b1, 1'(i % 2), 1'b1);
    tag = "R7";
    for (int i = 0; i < 32; i++) pix(8'($urandom), 2'd0, 1'b1, 1'b0, 1'b1);
    tag = "R8";
    for (int i = 0; i < 32; i++) pix(8'($urandom), 2'd0, 1'b1, 1'b1, 1'b1);
    tag = "R9";
    for (int i = 0; i < 8; i++) begin
      pix(8'd0, 2'd2, 1'b0, 1'b0, 1'b1);
      pix(8'd51, 2'd2, 1'b0, 1'b0, 1'b1);
      pix(8'(i * 37), 2'd2, 1'b0, 1'b0, 1'b1);
    end
    tag = "R2";
    for (int i = 0; i < 64; i++) pix(8'($urandom), 2'd2, 1'b0, 1'b0, 1'(i % 2));
    tag = "R3";
    for (int i = 0; i < 32; i++) pix(8'd51, 2'd2, 1'b0, 1'b0, 1'b0);
    tag = "R10";
    for (int r = 0; r < 4; r++) begin
      pix(8'd51, 2'd2, 1'b0, 1'b0, 1'b1);
      clut_we = 1'b1; clut_waddr = 8'd51;
      clut_wdata = {8'(10 + r * 60), 8'(240 - r * 50), 8'(r * 30), 6'(63 - r * 20)};
      pix(8'd51, 2'd2, 1'b0, 1'b0, 1'b1);
      pix(8'd51, 2'd2, 1'b0, 1'b0, 1'b1);
    end
    tag = "R11";
    for (int r = 0; r < 4; r++) begin
      pix(8'd2, 2'd1, 1'b1, 1'b0, 1'b1);
      map_we = 1'b1; map_waddr = 4'd2; map_wdata = 8'(17 + r * 55);
      pix(8'd2, 2'd1, 1'b1, 1'b0, 1'b1);
      pix(8'd2, 2'd1, 1'b1, 1'b0, 1'b1);
    end
    tag = "R2";
    repeat (4) pix(8'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule